// File: doc/BRIEF.md
# Scan-Port Debug and Bus Access Bridge

This block sits behind the instruction register of a boundary-scan test access port and implements its data-register side. The TAP state machine elsewhere supplies the current instruction value together with one-cycle capture, shift and update strobes, and the serial input bit. The block returns the serial output bit. The instruction value selects one of several data registers:

- a fixed identification word;
- an address and a 64-bit data path into a debug register file;
- an address and a 16-bit data path onto a Wishbone classic bus.

The bus data path issues single bus transfers.

Read data is loaded into the shared shift register on a capture strobe. Writes and bus transfers start on the update strobe. A debug write captures the old register contents, so one scan both returns the previous value and stores the new one. A bus read returns its result at the next capture under a bus-data instruction. A bus write-then-read stores the shifted word and then reads the same address back, and that readback is returned in the same way. Data shifts least significant bit first. The serial output is always bit 0 of the shift register.

Top module: `jtag_dbg_bridge`

## Requirements
- R1: After a synchronous active-low reset, the following all read 0: the serial output, the bus cycle strobe, the debug write strobe and both address registers.
- R2: Instruction value 1 selects a 32-bit register whose capture value is 0x000018FF.
- R3: Any instruction value without an assigned meaning selects a 1-bit register that captures 0. In that mode the serial output repeats each input bit one shift later.
- R4: Instruction value 5 selects an 8-bit debug address register. An update loads it from the shifted bits, a capture returns its current value, and it drives the debug address output.
- R5: Instruction value 6 selects a 64-bit register. A capture loads it with the debug read data at the latched debug address, and an update has no effect on the debug register file.
- R6: Instruction value 7 captures the same 64-bit debug read data. On update it drives the shifted word on the debug write data output, with the debug write strobe high for exactly one cycle.
- R7: Instruction value 8 selects a 16-bit bus address register. A capture returns the last value loaded by an update.
- R8: Instruction value 9 selects a 16-bit bus data register. A capture returns the result of the most recent completed bus read (0 after reset), and an update starts one bus read at the latched bus address.
- R9: Instruction value 10 uses the same 16-bit bus data register. An update writes the shifted word to the latched bus address and then reads that address, and the result is returned by the next bus-data capture.
- R10: During a bus transfer the cycle and strobe outputs are always equal. They stay high, with a stable address, until the acknowledge input is seen.
- R11: While a bus transfer is in progress, capture and update strobes are ignored: the shift register keeps its contents and no further transfer starts.
- R12: Each shift moves the selected register one place toward bit 0 and loads the input bit at its top position. The serial output is bit 0 of the shift register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (TCK domain) |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_value | input | 4 | Current instruction register value |
| capture_dr | input | 1 | One-cycle capture strobe |
| shift_dr | input | 1 | Shift enable, one bit per cycle |
| update_dr | input | 1 | One-cycle update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the shift register) |
| dbg_addr | output | 8 | Latched debug register address |
| dbg_rdata | input | 64 | Debug register contents at dbg_addr |
| dbg_wdata | output | 64 | Debug register write data |
| dbg_we | output | 1 | Debug register write strobe, one cycle |
| wb_adr_o | output | 16 | Bus address |
| wb_dat_o | output | 16 | Bus write data |
| wb_dat_i | input | 16 | Bus read data |
| wb_we_o | output | 1 | Bus write enable |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
The assertions rely on three properties of the inputs:

- The update strobe lasts a single cycle, which is what makes the one-cycle debug write pulse hold.
- Capture and shift are never high in the same cycle.
- The bus slave acknowledges only while a cycle is open.

The bench drives the strobes through one scan task that always issues a single capture cycle, then a run of shift cycles, then a single update cycle, with all inputs changed on the falling edge. Its bus slave model raises acknowledge only in response to an open strobe, after a programmable delay.

// File: rtl/jdb_pkg.sv
// Package: shared instruction codes and data-register select type for the
// scan-port debug bridge. Assumes a 4-bit or wider instruction register.
package jdb_pkg;

    localparam int IR_IDCODE = 1;
    localparam int IR_DADDR  = 5;
    localparam int IR_DREAD  = 6;
    localparam int IR_DWRRD  = 7;
    localparam int IR_BADDR  = 8;
    localparam int IR_BREAD  = 9;
    localparam int IR_BWRRD  = 10;

    typedef enum logic [2:0] {
        SEL_BYPASS,
        SEL_IDENT,
        SEL_DADDR,
        SEL_DREAD,
        SEL_DWRRD,
        SEL_BADDR,
        SEL_BREAD,
        SEL_BWRRD
    } dr_sel_e;

endpackage

// File: rtl/jdb_decode.sv
// Module: instruction decoder. Maps the instruction value to a data-register
// select and the index of that register's top bit in the shared shift
// register. Purely combinational; assumes every width fits in SR_W.
module jdb_decode
    import jdb_pkg::*;
#(
    parameter int IR_W   = 4,
    parameter int ID_W   = 32,
    parameter int DBG_AW = 8,
    parameter int DBG_DW = 64,
    parameter int BUS_AW = 16,
    parameter int BUS_DW = 16,
    parameter int IDX_W  = 6
) (
    input  logic [IR_W-1:0]  ir_value,
    output dr_sel_e          sel,
    output logic [IDX_W-1:0] top_idx
);

    // Select a data register and its length from the instruction value.
    always_comb begin
        case (ir_value)
            IR_W'(IR_IDCODE): begin sel = SEL_IDENT; top_idx = IDX_W'(ID_W - 1);   end
            IR_W'(IR_DADDR):  begin sel = SEL_DADDR; top_idx = IDX_W'(DBG_AW - 1); end
            IR_W'(IR_DREAD):  begin sel = SEL_DREAD; top_idx = IDX_W'(DBG_DW - 1); end
            IR_W'(IR_DWRRD):  begin sel = SEL_DWRRD; top_idx = IDX_W'(DBG_DW - 1); end
            IR_W'(IR_BADDR):  begin sel = SEL_BADDR; top_idx = IDX_W'(BUS_AW - 1); end
            IR_W'(IR_BREAD):  begin sel = SEL_BREAD; top_idx = IDX_W'(BUS_DW - 1); end
            IR_W'(IR_BWRRD):  begin sel = SEL_BWRRD; top_idx = IDX_W'(BUS_DW - 1); end
            default:          begin sel = SEL_BYPASS; top_idx = '0;               end
        endcase
    end

endmodule

// File: rtl/jdb_shreg.sv
// Module: shared serial shift register. Parallel load has priority over
// shift. A shift moves the word toward bit 0 and inserts the serial input
// at the top bit of the currently selected register length.
module jdb_shreg #(
    parameter int SR_W  = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SR_W-1:0]  load_val,
    input  logic             shift,
    input  logic             tdi,
    input  logic [IDX_W-1:0] top_idx,
    output logic [SR_W-1:0]  sr
);

    logic [SR_W-1:0] sr_next;

    // Compute the shifted word with the input bit placed at the top index.
    always_comb begin
        sr_next          = sr >> 1;
        sr_next[top_idx] = tdi;
    end

    // Register: reset, parallel load or one-bit shift.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= load_val;
        else if (shift) sr <= sr_next;
    end

endmodule

// File: rtl/jdb_wbm.sv
// Module: single-transfer Wishbone classic master. A read request performs
// one read. A write request performs a write, then a read of the same
// address. The result of the last read is held in rdata_hold. Requests are
// ignored while busy. Assumes the slave raises ack only while stb is high.
module jdb_wbm #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_rd,
    input  logic          start_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic [DW-1:0] rdata_hold,
    output logic [AW-1:0] wb_adr_o,
    output logic [DW-1:0] wb_dat_o,
    input  logic [DW-1:0] wb_dat_i,
    output logic          wb_we_o,
    output logic          wb_cyc_o,
    output logic          wb_stb_o,
    input  logic          wb_ack_i
);

    typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ} wbm_state_e;
    wbm_state_e state;

    // Transfer sequencing, address/data latching and read-result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            wb_adr_o   <= '0;
            wb_dat_o   <= '0;
            rdata_hold <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_wr) begin
                        state    <= ST_WRITE;
                        wb_adr_o <= addr;
                        wb_dat_o <= wdata;
                    end else if (start_rd) begin
                        state    <= ST_READ;
                        wb_adr_o <= addr;
                    end
                end
                ST_WRITE: if (wb_ack_i) state <= ST_READ;
                ST_READ: begin
                    if (wb_ack_i) begin
                        rdata_hold <= wb_dat_i;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus control lines follow the state.
    always_comb begin
        busy     = (state != ST_IDLE);
        wb_cyc_o = busy;
        wb_stb_o = busy;
        wb_we_o  = (state == ST_WRITE);
    end

    assert_cyc_stb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o == wb_stb_o);

    assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && $stable(wb_adr_o) && $stable(wb_we_o)));

endmodule

// File: rtl/jtag_dbg_bridge.sv
// Module: data-register side of a scan test port. Decodes the instruction,
// loads the shared shift register on capture and acts on update: it latches
// the addresses, pulses a debug register write, or starts bus transfers.
// Assumes one-cycle capture/update strobes and no capture during shift.
module jtag_dbg_bridge
    import jdb_pkg::*;
#(
    parameter int          IR_W     = 4,
    parameter int          ID_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h0000_18FF,
    parameter int          DBG_AW   = 8,
    parameter int          DBG_DW   = 64,
    parameter int          BUS_AW   = 16,
    parameter int          BUS_DW   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IR_W-1:0]   ir_value,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic [DBG_AW-1:0] dbg_addr,
    input  logic [DBG_DW-1:0] dbg_rdata,
    output logic [DBG_DW-1:0] dbg_wdata,
    output logic              dbg_we,
    output logic [BUS_AW-1:0] wb_adr_o,
    output logic [BUS_DW-1:0] wb_dat_o,
    input  logic [BUS_DW-1:0] wb_dat_i,
    output logic              wb_we_o,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    input  logic              wb_ack_i
);

    localparam int W1    = (ID_W > DBG_DW) ? ID_W : DBG_DW;
    localparam int W2    = (W1 > DBG_AW) ? W1 : DBG_AW;
    localparam int W3    = (W2 > BUS_AW) ? W2 : BUS_AW;
    localparam int SR_W  = (W3 > BUS_DW) ? W3 : BUS_DW;
    localparam int IDX_W = (SR_W > 1) ? $clog2(SR_W) : 1;

    dr_sel_e            sel;
    logic [IDX_W-1:0]   top_idx;
    logic [SR_W-1:0]    sr;
    logic [SR_W-1:0]    cap_val;
    logic [BUS_AW-1:0]  bus_addr;
    logic [BUS_DW-1:0]  bus_hold;
    logic               bus_busy;
    logic               cap_en;
    logic               upd_en;
    logic               start_rd;
    logic               start_wr;

    jdb_decode #(
        .IR_W(IR_W), .ID_W(ID_W), .DBG_AW(DBG_AW), .DBG_DW(DBG_DW),
        .BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .IDX_W(IDX_W)
    ) u_decode (
        .ir_value(ir_value),
        .sel     (sel),
        .top_idx (top_idx)
    );

    // Strobes are honoured only when no bus transfer is open.
    always_comb begin
        cap_en   = capture_dr && !bus_busy;
        upd_en   = update_dr  && !bus_busy;
        start_rd = upd_en && (sel == SEL_BREAD);
        start_wr = upd_en && (sel == SEL_BWRRD);
    end

    // Choose the parallel capture value for the selected register.
    always_comb begin
        cap_val = '0;
        case (sel)
            SEL_IDENT:             cap_val[ID_W-1:0]   = ID_VALUE[ID_W-1:0];
            SEL_DADDR:             cap_val[DBG_AW-1:0] = dbg_addr;
            SEL_DREAD, SEL_DWRRD:  cap_val[DBG_DW-1:0] = dbg_rdata;
            SEL_BADDR:             cap_val[BUS_AW-1:0] = bus_addr;
            SEL_BREAD, SEL_BWRRD:  cap_val[BUS_DW-1:0] = bus_hold;
            default:               cap_val = '0;
        endcase
    end

    jdb_shreg #(.SR_W(SR_W), .IDX_W(IDX_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cap_en),
        .load_val(cap_val),
        .shift   (shift_dr),
        .tdi     (tdi),
        .top_idx (top_idx),
        .sr      (sr)
    );

    assign tdo = sr[0];

    // Update actions: address latches and the debug write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_addr  <= '0;
            bus_addr  <= '0;
            dbg_wdata <= '0;
            dbg_we    <= 1'b0;
        end else begin
            dbg_we <= 1'b0;
            if (upd_en) begin
                case (sel)
                    SEL_DADDR: dbg_addr <= sr[DBG_AW-1:0];
                    SEL_BADDR: bus_addr <= sr[BUS_AW-1:0];
                    SEL_DWRRD: begin
                        dbg_wdata <= sr[DBG_DW-1:0];
                        dbg_we    <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    jdb_wbm #(.AW(BUS_AW), .DW(BUS_DW)) u_wbm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .addr      (bus_addr),
        .wdata     (sr[BUS_DW-1:0]),
        .busy      (bus_busy),
        .rdata_hold(bus_hold),
        .wb_adr_o  (wb_adr_o),
        .wb_dat_o  (wb_dat_o),
        .wb_dat_i  (wb_dat_i),
        .wb_we_o   (wb_we_o),
        .wb_cyc_o  (wb_cyc_o),
        .wb_stb_o  (wb_stb_o),
        .wb_ack_i  (wb_ack_i)
    );

    assert_capture_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_dr && !shift_dr && wb_cyc_o) |=> $stable(sr));

    assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && wb_ack_i && !wb_we_o) |=> !wb_cyc_o);

    assert_write_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_we |=> !dbg_we);

endmodule

// File: tb/sim_jtag_dbg_bridge.sv
module sim_jtag_dbg_bridge;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  ir;
        logic [6:0]  len;
        logic [63:0] din;
        logic [63:0] expv;
        logic [7:0]  req;
    } vec_t;

    // Scan table; executed in order, each entry followed by bus-idle wait.
    localparam vec_t VECS [14] = '{
        '{4'd1,  7'd32, 64'h0,                   64'h18FF,                8'd2},  // R2
        '{4'd5,  7'd8,  64'h01,                  64'h00,                  8'd4},  // R4 reset value
        '{4'd5,  7'd8,  64'h01,                  64'h01,                  8'd4},  // R4 readback
        '{4'd6,  7'd64, 64'h0,                   64'h0123_4567_89AB_CDEF, 8'd5},  // R5
        '{4'd7,  7'd64, 64'hDEAD_BEEF_0000_0005, 64'h0123_4567_89AB_CDEF, 8'd6},  // R6 old value
        '{4'd6,  7'd64, 64'h0,                   64'hDEAD_BEEF_0000_0005, 8'd6},  // R6 new value
        '{4'd8,  7'd16, 64'h0003,                64'h0000,                8'd7},  // R7
        '{4'd8,  7'd16, 64'h0003,                64'h0003,                8'd7},  // R7
        '{4'd9,  7'd16, 64'h0,                   64'h0000,                8'd8},  // R8 reset hold
        '{4'd9,  7'd16, 64'h0,                   64'h1003,                8'd8},  // R8
        '{4'd10, 7'd16, 64'hFEEF,                64'h1003,                8'd9},  // R9
        '{4'd9,  7'd16, 64'h0,                   64'hFEEF,                8'd9},  // R9
        '{4'd15, 7'd1,  64'h1,                   64'h0,                   8'd3},  // R3
        '{4'd15, 7'd5,  64'h16,                  64'h0C,                  8'd12}  // R3, R12
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  ir_value;
    logic        capture_dr, shift_dr, update_dr, tdi, tdo;
    logic [7:0]  dbg_addr;
    logic [63:0] dbg_rdata, dbg_wdata;
    logic        dbg_we;
    logic [15:0] wb_adr_o, wb_dat_o, wb_dat_i;
    logic        wb_we_o, wb_cyc_o, wb_stb_o, wb_ack_i;

    int checks = 0;
    int errors = 0;

    logic [63:0] dmem [4];
    logic [15:0] bmem [16];
    int          ack_delay;
    int          ack_cnt;
    int          n_acks;
    int          n_dbg_we;
    int          n_bus_viol;
    logic        prev_cyc, prev_ack;
    logic [15:0] prev_adr;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtag_dbg_bridge u0 (
        .clk(clk), .rst_n(rst_n), .ir_value(ir_value),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo),
        .dbg_addr(dbg_addr), .dbg_rdata(dbg_rdata), .dbg_wdata(dbg_wdata), .dbg_we(dbg_we),
        .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
        .wb_we_o(wb_we_o), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_ack_i(wb_ack_i)
    );

    // Debug register file model.
    assign dbg_rdata = dmem[dbg_addr[1:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            dmem[0] <= 64'hA5A5_0000_1234_5678;
            dmem[1] <= 64'h0123_4567_89AB_CDEF;
            dmem[2] <= 64'h0;
            dmem[3] <= 64'hFFFF_FFFF_FFFF_FFFF;
        end else if (dbg_we) begin
            dmem[dbg_addr[1:0]] <= dbg_wdata;
        end
    end

    // Bus slave model with programmable acknowledge delay.
    assign wb_dat_i = bmem[wb_adr_o[3:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) bmem[k] <= 16'h1000 + 16'(k);
            wb_ack_i <= 1'b0;
            ack_cnt  <= 0;
        end else if (wb_cyc_o && wb_stb_o && !wb_ack_i) begin
            if (ack_cnt >= ack_delay) begin
                wb_ack_i <= 1'b1;
                ack_cnt  <= 0;
                if (wb_we_o) bmem[wb_adr_o[3:0]] <= wb_dat_o;
            end else begin
                ack_cnt <= ack_cnt + 1;
            end
        end else begin
            wb_ack_i <= 1'b0;
        end
    end

    // Monitors: transfer count, debug write cycles, bus handshake rules (R10).
    always @(posedge clk) begin
        if (!rst_n) begin
            n_acks <= 0; n_dbg_we <= 0; n_bus_viol <= 0;
            prev_cyc <= 1'b0; prev_ack <= 1'b0; prev_adr <= '0;
        end else begin
            if (wb_cyc_o && wb_ack_i) n_acks <= n_acks + 1;
            if (dbg_we) n_dbg_we <= n_dbg_we + 1;
            if ((wb_cyc_o != wb_stb_o) ||
                (prev_cyc && !prev_ack && (!wb_cyc_o || wb_adr_o != prev_adr)))
                n_bus_viol <= n_bus_viol + 1;
            prev_cyc <= wb_cyc_o; prev_ack <= wb_ack_i; prev_adr <= wb_adr_o;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    // One full data-register scan: capture, len shifts, update.
    task automatic scan(input logic [3:0] ir, input int len, input logic [63:0] din,
                        output logic [63:0] dout);
        dout = '0;
        @(negedge clk);
        ir_value   = ir;
        capture_dr = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0;
        for (int i = 0; i < len; i++) begin
            dout[i]  = tdo;
            shift_dr = 1'b1;
            tdi      = din[i];
            @(negedge clk);
        end
        shift_dr  = 1'b0;
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && wb_cyc_o; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [63:0] res;
        int          n0;
        rst_n = 1'b0; ir_value = '0; capture_dr = 1'b0; shift_dr = 1'b0;
        update_dr = 1'b0; tdi = 1'b0; ack_delay = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 tdo", 64'(tdo), 64'h0);
        check("R1 cyc", 64'(wb_cyc_o), 64'h0);
        check("R1 dbg_we", 64'(dbg_we), 64'h0);
        check("R1 dbg_addr", 64'(dbg_addr), 64'h0);

        for (int v = 0; v < 14; v++) begin
            scan(VECS[v].ir, int'(VECS[v].len), VECS[v].din, res);
            wait_idle();
            checks++;
            if (res !== VECS[v].expv) begin
                errors++;
                $display("FAIL R%0d vector %0d: got %h expected %h",
                         VECS[v].req, v, res, VECS[v].expv);
            end
        end

        // R4 address output, R6 single write pulse, R5 read caused no write
        check("R4 dbg_addr port", 64'(dbg_addr), 64'h01);
        check("R6 dbg_we cycles", 64'(n_dbg_we), 64'd1);

        // R11: capture/update while a slow transfer is open
        ack_delay = 40;
        n0 = n_acks;
        scan(4'd9, 16, 64'h1234, res);          // launches read of addr 3
        check("R8 hold before slow read", res, 64'hFEEF);
        scan(4'd9, 16, 64'h0, res);             // capture and update while busy
        check("R11 capture ignored", res, 64'h1234);
        check("R11 bus still open", 64'(wb_cyc_o), 64'h1);
        wait_idle();
        check("R11 single transfer", 64'(n_acks - n0), 64'd1);
        ack_delay = 0;
        scan(4'd9, 16, 64'h0, res);
        wait_idle();
        check("R8 slow read result", res, 64'hFEEF);

        check("R10 bus handshake violations", 64'(n_bus_viol), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule